// File: doc/BRIEF.md
# Flash Readout Protection Controller

The block guards an on-chip flash array. It holds a one-byte protection word and decides, request by request, whether an access may reach the array. Three requesters feed it: a parallel programming port and a serial programming port, each of which can ask for a read, a program, an erase or a write of the protection word, and a tester port that can only ask to read. Every decision comes out one clock after the request as a registered grant, or as a one-cycle refusal pulse. Read data is routed through the block so that a refused read never shows the array contents.

The protection word has two protection-level fields and one release field. The effective level is computed from the stored word at all times and is reported at the ports. Level 1 closes the parallel port. Level 2 also closes the tester port. When protection is active, the parallel port can no longer change the word, so only the serial port can lift protection.

Top module: `flash_guard`

## Requirements
- R1: After a synchronous reset the protection word reads 0xFF, the effective level is 0, all grants and `access_denied` are low, and all read-data outputs are 0xFF.
- R2: Bits [1:0] of the protection word read as 1 after every accepted write, whatever the written value.
- R3: The level-1 field is bits [3:2] and the level-2 field is bits [7:6]. A field equal to 2'b11 leaves its level off. Any of 2'b00, 2'b01 or 2'b10 turns it on. The level is output on `prot_level` as 0, 1 or 2.
- R4: When the release field (bits [5:4]) is 2'b00, `prot_level` is 0 whatever the level fields hold.
- R5: When both level fields are on and release is not 2'b00, `prot_level` is 2.
- R6: A parallel read (op 2'b00), program (2'b01) or erase (2'b10) sets `par_grant` in the cycle after the request if `prot_level` was 0 when the request was sampled. Otherwise it is refused.
- R7: After a granted read, the port's read-data output carries the array data sampled with the request. After a refused read, or when no read was made, it is 0xFF.
- R8: A tester readout is granted at level 0 or 1 and refused at level 2.
- R9: A protection-word write (op 2'b11) from the parallel port is accepted only at level 0. At level 1 or 2 the whole word, including the release field, is left unchanged and the write is refused.
- R10: Serial-port requests of every kind are always granted. A serial word write takes priority over a parallel write in the same cycle. The new level is visible on `prot_level` right after the clock edge that stores the word.
- R11: `access_denied` is high in exactly those cycles that follow a sampled edge at which at least one request was refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_valid | input | 1 | Parallel-port request valid |
| par_op | input | 2 | Parallel op: 00 read, 01 program, 10 erase, 11 word write |
| par_wdata | input | 8 | Parallel-port protection word value |
| ser_valid | input | 1 | Serial-port request valid |
| ser_op | input | 2 | Serial op, same encoding |
| ser_wdata | input | 8 | Serial-port protection word value |
| tst_valid | input | 1 | Tester readout request |
| arr_rdata | input | DATA_W | Data from the flash array for the current read |
| par_grant | output | 1 | Parallel flash access granted (registered) |
| ser_grant | output | 1 | Serial request granted (registered) |
| tst_grant | output | 1 | Tester readout granted (registered) |
| access_denied | output | 1 | A request was refused at the last edge |
| par_rdata | output | DATA_W | Parallel read data, all ones unless a read was granted |
| ser_rdata | output | DATA_W | Serial read data, all ones unless a read was made |
| tst_rdata | output | DATA_W | Tester read data, all ones unless granted |
| prot_level | output | 2 | Effective protection level |
| ctrl_byte | output | 8 | Stored protection word |

## Verification
A corrupted protection word shows up on `prot_level` and `ctrl_byte` right after the edge that stores it, so every word write is followed by a comparison of both outputs in that same cycle. A wrong decode of a level or release field appears one cycle later as a grant where a refusal was expected, or the reverse, and as a read-data value that is not 0xFF. A broken parallel-port lock lets `ctrl_byte` change after a refused write. The bench therefore reads the word back after each attempted write and then probes the ports again to confirm that the level did not move.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int CTRL_W  = 8;
  localparam int FIELD_W = 2;
  localparam int L1_LSB  = 2;
  localparam int REL_LSB = 4;
  localparam int L2_LSB  = 6;
  localparam logic [FIELD_W-1:0] FIELD_OFF = 2'b11;
  localparam logic [FIELD_W-1:0] REL_OPEN  = 2'b00;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_CTRL  = 2'b11
  } fg_op_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_TWO  = 2'd2
  } fg_level_e;
endpackage

// File: rtl/fg_ctrl_reg.sv
module fg_ctrl_reg
  import flash_guard_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_we,
  input  logic [CTRL_W-1:0] par_wdata,
  input  logic              ser_we,
  input  logic [CTRL_W-1:0] ser_wdata,
  input  logic              locked_i,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [CTRL_W-1:0] RSV_ONES = CTRL_W'(2'b11);

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= RESET_VAL;
    else if (ser_we)
      ctrl_q <= ser_wdata | RSV_ONES;
    else if (par_we && !locked_i)
      ctrl_q <= par_wdata | RSV_ONES;
  end

  // R9
  par_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (par_we && !ser_we && locked_i) |=> $stable(ctrl_q));

  // R2
  rsv_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_we || par_we) |=> (ctrl_q[1:0] == 2'b11));

  // R1
  reset_val_chk: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_q == RESET_VAL));
endmodule

// File: rtl/fg_level_decode.sv
module fg_level_decode
  import flash_guard_pkg::*;
(
  input  logic [CTRL_W-1:2] ctrl_i,
  output logic [1:0]        level_o
);
  logic l1_on, l2_on, released;

  always_comb begin
    l1_on    = ctrl_i[L1_LSB  +: FIELD_W] != FIELD_OFF;
    l2_on    = ctrl_i[L2_LSB  +: FIELD_W] != FIELD_OFF;
    released = ctrl_i[REL_LSB +: FIELD_W] == REL_OPEN;
    if (released)   level_o = LVL_NONE;
    else if (l2_on) level_o = LVL_TWO;
    else if (l1_on) level_o = LVL_ONE;
    else            level_o = LVL_NONE;
  end
endmodule

// File: rtl/fg_access_gate.sv
module fg_access_gate
  import flash_guard_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_valid,
  input  logic [1:0]        par_op,
  input  logic              ser_valid,
  input  logic [1:0]        ser_op,
  input  logic              tst_valid,
  input  logic [1:0]        level,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              par_grant,
  output logic              ser_grant,
  output logic              tst_grant,
  output logic              access_denied,
  output logic [DATA_W-1:0] par_rdata,
  output logic [DATA_W-1:0] ser_rdata,
  output logic [DATA_W-1:0] tst_rdata
);
  localparam logic [DATA_W-1:0] BLANK = '1;

  logic par_flash, par_ok, par_ctrl_bad, tst_ok, deny_d;

  always_comb begin
    par_flash    = par_valid && (fg_op_e'(par_op) != OP_CTRL);
    par_ok       = par_flash && (level == LVL_NONE);
    par_ctrl_bad = par_valid && (fg_op_e'(par_op) == OP_CTRL) && (level != LVL_NONE);
    tst_ok       = tst_valid && (level != LVL_TWO);
    deny_d       = (par_flash && !par_ok) || par_ctrl_bad || (tst_valid && !tst_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_grant     <= 1'b0;
      ser_grant     <= 1'b0;
      tst_grant     <= 1'b0;
      access_denied <= 1'b0;
      par_rdata     <= BLANK;
      ser_rdata     <= BLANK;
      tst_rdata     <= BLANK;
    end else begin
      par_grant     <= par_ok;
      ser_grant     <= ser_valid;
      tst_grant     <= tst_ok;
      access_denied <= deny_d;
      par_rdata     <= (par_ok && fg_op_e'(par_op) == OP_READ) ? arr_rdata : BLANK;
      ser_rdata     <= (ser_valid && fg_op_e'(ser_op) == OP_READ) ? arr_rdata : BLANK;
      tst_rdata     <= tst_ok ? arr_rdata : BLANK;
    end
  end

  // R6
  par_gate_chk: assert property (@(posedge clk) disable iff (rst)
    par_grant |-> ($past(level) == LVL_NONE));

  // R8
  tst_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tst_grant |-> ($past(level) != LVL_TWO));

  // R7
  masked_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $past(par_valid && par_op == 2'b00 && level != 2'd0) |-> (par_rdata == BLANK));

  // R11
  deny_src_chk: assert property (@(posedge clk) disable iff (rst)
    access_denied |-> $past(par_valid || tst_valid));

  // R10
  ser_open_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ser_valid) |-> ser_grant);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_valid,
  input  logic [1:0]        par_op,
  input  logic [7:0]        par_wdata,
  input  logic              ser_valid,
  input  logic [1:0]        ser_op,
  input  logic [7:0]        ser_wdata,
  input  logic              tst_valid,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              par_grant,
  output logic              ser_grant,
  output logic              tst_grant,
  output logic              access_denied,
  output logic [DATA_W-1:0] par_rdata,
  output logic [DATA_W-1:0] ser_rdata,
  output logic [DATA_W-1:0] tst_rdata,
  output logic [1:0]        prot_level,
  output logic [7:0]        ctrl_byte
);
  logic par_we, ser_we, locked;

  assign par_we = par_valid && (fg_op_e'(par_op) == OP_CTRL);
  assign ser_we = ser_valid && (fg_op_e'(ser_op) == OP_CTRL);
  assign locked = prot_level != LVL_NONE;

  fg_ctrl_reg #(.RESET_VAL(RESET_VAL)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .par_we    (par_we),
    .par_wdata (par_wdata),
    .ser_we    (ser_we),
    .ser_wdata (ser_wdata),
    .locked_i  (locked),
    .ctrl_q    (ctrl_byte)
  );

  fg_level_decode u_dec (
    .ctrl_i  (ctrl_byte[CTRL_W-1:2]),
    .level_o (prot_level)
  );

  fg_access_gate #(.DATA_W(DATA_W)) u_gate (
    .clk           (clk),
    .rst           (rst),
    .par_valid     (par_valid),
    .par_op        (par_op),
    .ser_valid     (ser_valid),
    .ser_op        (ser_op),
    .tst_valid     (tst_valid),
    .level         (prot_level),
    .arr_rdata     (arr_rdata),
    .par_grant     (par_grant),
    .ser_grant     (ser_grant),
    .tst_grant     (tst_grant),
    .access_denied (access_denied),
    .par_rdata     (par_rdata),
    .ser_rdata     (ser_rdata),
    .tst_rdata     (tst_rdata)
  );
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_valid = 1'b0, ser_valid = 1'b0, tst_valid = 1'b0;
  logic [1:0] par_op = 2'b00, ser_op = 2'b00;
  logic [7:0] par_wdata = 8'h00, ser_wdata = 8'h00;
  logic [3:0] addr = 4'd0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] arr_rdata;
  logic par_grant, ser_grant, tst_grant, access_denied;
  logic [DW-1:0] par_rdata, ser_rdata, tst_rdata;
  logic [1:0] prot_level;
  logic [7:0] ctrl_byte;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign arr_rdata = mem[addr];

  flash_guard #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .par_valid(par_valid), .par_op(par_op), .par_wdata(par_wdata),
    .ser_valid(ser_valid), .ser_op(ser_op), .ser_wdata(ser_wdata),
    .tst_valid(tst_valid), .arr_rdata(arr_rdata),
    .par_grant(par_grant), .ser_grant(ser_grant), .tst_grant(tst_grant),
    .access_denied(access_denied),
    .par_rdata(par_rdata), .ser_rdata(ser_rdata), .tst_rdata(tst_rdata),
    .prot_level(prot_level), .ctrl_byte(ctrl_byte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle of requests, return just after the sampling edge
  task automatic issue(input logic pv, input logic [1:0] po, input logic [7:0] pw,
                       input logic sv, input logic [1:0] so, input logic [7:0] sw,
                       input logic tv);
    @(negedge clk);
    par_valid = pv; par_op = po; par_wdata = pw;
    ser_valid = sv; ser_op = so; ser_wdata = sw;
    tst_valid = tv;
    @(posedge clk); #1;
    par_valid = 1'b0; ser_valid = 1'b0; tst_valid = 1'b0;
  endtask

  task automatic ser_write(input logic [7:0] v);
    issue(1'b0, 2'b00, 8'h00, 1'b1, 2'b11, v, 1'b0);
  endtask

  task automatic par_req(input logic [1:0] op);
    issue(1'b1, op, 8'h00, 1'b0, 2'b00, 8'h00, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 ctrl", ctrl_byte, 8'hFF);
    check("R1 level", prot_level, 2'd0);
    check("R1 grants", {par_grant, ser_grant, tst_grant, access_denied}, 4'b0);
    check("R1 rdata", {par_rdata, ser_rdata, tst_rdata}, 24'hFFFFFF);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_open_access;
    addr = 4'd3;
    par_req(2'b00);
    check("R6 read grant", par_grant, 1'b1);
    check("R7 read data", par_rdata, mem[3]);
    check("R11 no deny", access_denied, 1'b0);
    par_req(2'b01);
    check("R6 prog grant", par_grant, 1'b1);
    check("R7 no read blank", par_rdata, 8'hFF);
    par_req(2'b10);
    check("R6 erase grant", par_grant, 1'b1);
    issue(1'b0, 2'b00, 8'h00, 1'b0, 2'b00, 8'h00, 1'b1);
    check("R8 tester open", {tst_grant, tst_rdata}, {1'b1, mem[3]});
  endtask

  task automatic t_level_one;
    ser_write(8'hF4);
    check("R2 reserved", ctrl_byte, 8'hF7);
    check("R3 field 01", prot_level, 2'd1);
    addr = 4'd5;
    par_req(2'b00);
    check("R6 read refused", par_grant, 1'b0);
    check("R7 refused blank", par_rdata, 8'hFF);
    check("R11 deny pulse", access_denied, 1'b1);
    issue(1'b0, 2'b00, 8'h00, 1'b0, 2'b00, 8'h00, 1'b0);
    check("R11 deny drops", access_denied, 1'b0);
    par_req(2'b10);
    check("R6 erase refused", {par_grant, access_denied}, 2'b01);
    issue(1'b0, 2'b00, 8'h00, 1'b0, 2'b00, 8'h00, 1'b1);
    check("R8 tester at lvl1", {tst_grant, tst_rdata, access_denied}, {1'b1, mem[5], 1'b0});
    ser_write(8'hFB);
    check("R3 field 10", prot_level, 2'd1);
    ser_write(8'hF3);
    check("R3 field 00", prot_level, 2'd1);
  endtask

  task automatic t_level_two;
    ser_write(8'h3F);
    check("R3 l2 field 00", prot_level, 2'd2);
    issue(1'b0, 2'b00, 8'h00, 1'b0, 2'b00, 8'h00, 1'b1);
    check("R8 tester refused", {tst_grant, tst_rdata, access_denied}, {1'b0, 8'hFF, 1'b1});
    ser_write(8'h7F);
    check("R3 l2 field 01", prot_level, 2'd2);
    ser_write(8'hBF);
    check("R3 l2 field 10", prot_level, 2'd2);
    ser_write(8'h33);
    check("R5 both levels", prot_level, 2'd2);
    addr = 4'd7;
    issue(1'b0, 2'b00, 8'h00, 1'b1, 2'b00, 8'h00, 1'b0);
    check("R10 serial read at lvl2", {ser_grant, ser_rdata}, {1'b1, mem[7]});
  endtask

  task automatic t_release;
    ser_write(8'h03);
    check("R4 release all", prot_level, 2'd0);
    addr = 4'd9;
    par_req(2'b00);
    check("R4 read after release", {par_grant, par_rdata}, {1'b1, mem[9]});
  endtask

  task automatic t_par_lock;
    issue(1'b1, 2'b11, 8'hF4, 1'b0, 2'b00, 8'h00, 1'b0);
    check("R9 open par write", ctrl_byte, 8'hF7);
    check("R9 open no deny", access_denied, 1'b0);
    check("R10 level next cycle", prot_level, 2'd1);
    issue(1'b1, 2'b11, 8'hCF, 1'b0, 2'b00, 8'h00, 1'b0);
    check("R9 release locked", ctrl_byte, 8'hF7);
    check("R9 lock deny", access_denied, 1'b1);
    check("R9 level kept", prot_level, 2'd1);
    issue(1'b1, 2'b11, 8'hFF, 1'b0, 2'b00, 8'h00, 1'b0);
    check("R9 level bits locked", ctrl_byte, 8'hF7);
    ser_write(8'hCF);
    check("R10 serial release", {ctrl_byte, prot_level}, {8'hCF, 2'd0});
    par_req(2'b01);
    check("R10 open next cycle", par_grant, 1'b1);
  endtask

  task automatic t_both_writers;
    ser_write(8'hFF);
    issue(1'b1, 2'b11, 8'h77, 1'b1, 2'b11, 8'hDC, 1'b0);
    check("R10 serial wins", ctrl_byte, 8'hDF);
    check("R2 reserved on serial", ctrl_byte[1:0], 2'b11);
    check("R10 ser grant", ser_grant, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'h21 * i + 8'h0A);
    t_reset;
    t_open_access;
    t_level_one;
    t_level_two;
    t_release;
    t_reset;
    t_par_lock;
    t_both_writers;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule